// File: doc/BRIEF.md
# Up-Counting Timer with Selectable Trigger Output

This block is a general-purpose up-counter with a programmable clock divider, a reload limit and four compare channels. It drives one trigger line that other logic, typically a converter sequencer, uses to pace its conversions. A 3-bit source selector picks which internal timer event appears on that line.

Software reaches the timer through a small word-wide port. A write takes effect on the clock edge where `wr_en` is high. A read returns data in `rdata` on the edge after `rd_en` is high.

The divider setting is always staged and only becomes active on an update event. The reload limit is staged only when its preload bit is set. An update event is either a counter wrap or a software-forced update.

Top module: `gp_timer_trig`

## Requirements
- R1: After reset, every register, the counter, `rdata` and `trgo` are zero.
- R2: The active divider value P (written at address 1, committed on an update event) makes the counter advance once every P+1 clock cycles while running, so P=0 advances it every cycle.
- R3: The counter runs 0,1,...,A and then wraps to 0, where A is the reload value at address 2, giving A+1 counts per period.
- R4: With the preload bit set (address 0, bit 1), a write to address 2 changes the period only after the next update event; with the bit clear, it changes the period at once.
- R5: The run bit (address 0, bit 0) makes the counter advance when 1 and holds the count (read at address 6) unchanged when 0.
- R6: Writing 1 to bit 0 of address 4 forces an update: the counter and divider restart from 0 and the staged values become active. Address 4 always reads 0.
- R7: The source selector (address 0, bits 6:4) chooses the trigger source, and `trgo` is registered:
  - 0: a one-cycle pulse after each forced update.
  - 1: the run bit, one cycle late.
  - 2: a one-cycle pulse in the first cycle of count 0 after every wrap and after every forced update.
- R8: With selector value 3, `trgo` pulses for one cycle when the count newly reaches the channel 0 compare value (address 8), but only while enable bit 0 of address 3 is set.
- R9: With selector 4+k (k=0..3), `trgo` is high exactly in the cycles where the count is less than the compare value of channel k (address 8+k).
- R10: Address 5 reads the update flag in bit 0 and the run bit in bit 1. The flag is set by every update event and cleared by writing 1 to bit 0 of address 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| trgo | output | 1 | Selected trigger output |

## Verification
The hardest situation to reach from the ports is a staged reload value that is written in the middle of a running period. The old period must finish before the new one takes over.

The stimulus programs a short period with preload enabled and waits for a wrap pulse on `trgo` in update mode. It then writes a longer reload value within two cycles of that pulse. It timestamps the next two pulses, so the interval that must still use the old value can be told apart from the one that must use the new value. The same timestamped pulse intervals measure the divider and period arithmetic.

// File: rtl/gtt_pkg.sv
package gtt_pkg;

  localparam int ADDR_W = 4;
  localparam int NUM_CH = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'h1;
  localparam logic [ADDR_W-1:0] A_LIMIT = 4'h2;
  localparam logic [ADDR_W-1:0] A_CHEN  = 4'h3;
  localparam logic [ADDR_W-1:0] A_FORCE = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h5;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'h6;
  localparam int                A_CMP0  = 8;

  typedef enum logic [2:0] {
    SRC_FORCE  = 3'd0,
    SRC_RUN    = 3'd1,
    SRC_UPDATE = 3'd2,
    SRC_MATCH  = 3'd3,
    SRC_LVL0   = 3'd4,
    SRC_LVL1   = 3'd5,
    SRC_LVL2   = 3'd6,
    SRC_LVL3   = 3'd7
  } src_sel_e;

endpackage

// File: rtl/gtt_regs.sv
module gtt_regs
  import gtt_pkg::*;
#(
  parameter int DW  = 16,
  parameter int PW  = 16,
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DW-1:0]            wdata,
  input  logic [CW-1:0]            cnt,
  input  logic                     upd_evt,
  output logic                     run,
  output logic                     arpe,
  output src_sel_e                 src_sel,
  output logic [PW-1:0]            div_stage,
  output logic [CW-1:0]            lim_stage,
  output logic [NCH-1:0][CW-1:0]   cmp,
  output logic [NCH-1:0]           ch_en,
  output logic                     force_upd,
  output logic                     upd_flag,
  output logic [DW-1:0]            rdata
);

  logic [DW-1:0] rd_mux;

  // Software-forced update is a single-cycle strobe from the write decode
  always_comb force_upd = wr_en && (addr == A_FORCE) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      arpe      <= 1'b0;
      src_sel   <= SRC_FORCE;
      div_stage <= '0;
      lim_stage <= '0;
      ch_en     <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run     <= wdata[0];
          arpe    <= wdata[1];
          src_sel <= src_sel_e'(wdata[6:4]);
        end
        A_DIV:   div_stage <= wdata[PW-1:0];
        A_LIMIT: lim_stage <= wdata[CW-1:0];
        A_CHEN:  ch_en     <= wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)
          cmp[k] <= '0;
        else if (wr_en && (addr == ADDR_W'(A_CMP0 + k)))
          cmp[k] <= wdata[CW-1:0];
      end
    end
  endgenerate

  // Update flag: set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      upd_flag <= 1'b0;
    else if (upd_evt)
      upd_flag <= 1'b1;
    else if (wr_en && (addr == A_STAT) && wdata[0])
      upd_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux = DW'({src_sel, 2'b00, arpe, run});
      A_DIV:   rd_mux = DW'(div_stage);
      A_LIMIT: rd_mux = DW'(lim_stage);
      A_CHEN:  rd_mux = DW'(ch_en);
      A_STAT:  rd_mux = DW'({run, upd_flag});
      A_COUNT: rd_mux = DW'(cnt);
      default: rd_mux = '0;
    endcase
    for (int k = 0; k < NCH; k++) begin
      if (addr == ADDR_W'(A_CMP0 + k))
        rd_mux = DW'(cmp[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

endmodule

// File: rtl/gtt_count.sv
module gtt_count #(
  parameter int PW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          arpe,
  input  logic          force_upd,
  input  logic [PW-1:0] div_stage,
  input  logic [CW-1:0] lim_stage,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          cnt_chg,
  output logic          upd_evt,
  output logic [PW-1:0] div_act
);

  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] lim_act;
  logic [CW-1:0] lim_eff;
  logic          tick;
  logic          wrap;

  // Without preload the staged limit is used directly
  always_comb lim_eff = arpe ? lim_act : lim_stage;
  always_comb tick    = run && (pre_cnt == div_act);
  always_comb wrap    = tick && (cnt >= lim_eff) && !force_upd;
  always_comb upd_evt = force_upd || wrap;
  always_comb cnt_chg = force_upd || tick;

  always_comb begin
    if (force_upd || wrap)
      cnt_nxt = '0;
    else if (tick)
      cnt_nxt = cnt + 1'b1;
    else
      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (force_upd || tick) begin
      pre_cnt <= '0;
    end else if (run) begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      div_act <= '0;
      lim_act <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (upd_evt) begin
        div_act <= div_stage;
        lim_act <= lim_stage;
      end
    end
  end

endmodule

// File: rtl/gtt_compare.sv
module gtt_compare #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic [CW-1:0]          cnt_nxt,
  input  logic                   cnt_chg,
  input  logic [NCH-1:0][CW-1:0] cmp,
  input  logic [NCH-1:0]         ch_en,
  output logic [NCH-1:0]         lvl_nxt,
  output logic                   hit0
);

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_lvl
      always_comb lvl_nxt[k] = (cnt_nxt < cmp[k]);
    end
  endgenerate

  always_comb hit0 = ch_en[0] && cnt_chg && (cnt_nxt == cmp[0]);

endmodule

// File: rtl/gtt_trgo.sv
module gtt_trgo
  import gtt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  src_sel_e       src_sel,
  input  logic           run,
  input  logic           force_upd,
  input  logic           upd_evt,
  input  logic           hit0,
  input  logic [NCH-1:0] lvl_nxt,
  output logic           trgo
);

  logic trgo_nxt;

  always_comb begin
    case (src_sel)
      SRC_FORCE:  trgo_nxt = force_upd;
      SRC_RUN:    trgo_nxt = run;
      SRC_UPDATE: trgo_nxt = upd_evt;
      SRC_MATCH:  trgo_nxt = hit0;
      default:    trgo_nxt = lvl_nxt[src_sel[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trgo <= 1'b0;
    else     trgo <= trgo_nxt;
  end

endmodule

// File: rtl/gp_timer_trig.sv
module gp_timer_trig
  import gtt_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              trgo
);

  localparam int NCH = NUM_CH;

  logic                   run;
  logic                   arpe;
  src_sel_e               src_sel;
  logic [PW-1:0]          div_stage;
  logic [PW-1:0]          div_act;
  logic [CW-1:0]          lim_stage;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-1:0]         ch_en;
  logic                   force_upd;
  logic                   upd_flag;
  logic                   upd_evt;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          cnt_nxt;
  logic                   cnt_chg;
  logic [NCH-1:0]         lvl_nxt;
  logic                   hit0;

  gtt_regs #(.DW(DW), .PW(PW), .CW(CW), .NCH(NCH)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt       (cnt),
    .upd_evt   (upd_evt),
    .run       (run),
    .arpe      (arpe),
    .src_sel   (src_sel),
    .div_stage (div_stage),
    .lim_stage (lim_stage),
    .cmp       (cmp),
    .ch_en     (ch_en),
    .force_upd (force_upd),
    .upd_flag  (upd_flag),
    .rdata     (rdata)
  );

  gtt_count #(.PW(PW), .CW(CW)) u_count (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .arpe      (arpe),
    .force_upd (force_upd),
    .div_stage (div_stage),
    .lim_stage (lim_stage),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt),
    .cnt_chg   (cnt_chg),
    .upd_evt   (upd_evt),
    .div_act   (div_act)
  );

  gtt_compare #(.CW(CW), .NCH(NCH)) u_cmp (
    .cnt_nxt (cnt_nxt),
    .cnt_chg (cnt_chg),
    .cmp     (cmp),
    .ch_en   (ch_en),
    .lvl_nxt (lvl_nxt),
    .hit0    (hit0)
  );

  gtt_trgo #(.NCH(NCH)) u_trgo (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .run       (run),
    .force_upd (force_upd),
    .upd_evt   (upd_evt),
    .hit0      (hit0),
    .lvl_nxt   (lvl_nxt),
    .trgo      (trgo)
  );

endmodule

// File: rtl/gtt_checker.sv
module gtt_checker
  import gtt_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic              run,
  input src_sel_e          src_sel,
  input logic              upd_evt,
  input logic [CW-1:0]     cnt,
  input logic [PW-1:0]     div_act,
  input logic              ch_en0,
  input logic              upd_flag,
  input logic              trgo
);

  p_force_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_FORCE && wdata[0]) |=> (cnt == '0));

  p_hold_when_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && addr == A_FORCE && wdata[0])) |=> $stable(cnt));

  p_div_commit_only_on_update_r2: assert property (@(posedge clk) disable iff (rst)
    !upd_evt |=> $stable(div_act));

  p_run_level_r7: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_RUN) |=> (trgo == $past(run)));

  p_update_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_UPDATE && upd_evt) |=> trgo);

  p_match_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_MATCH && !ch_en0) |=> !trgo);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> upd_flag);

endmodule

bind gp_timer_trig gtt_checker #(.DW(DW), .PW(PW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .run      (run),
  .src_sel  (src_sel),
  .upd_evt  (upd_evt),
  .cnt      (cnt),
  .div_act  (div_act),
  .ch_en0   (ch_en[0]),
  .upd_flag (upd_flag),
  .trgo     (trgo)
);

// File: tb/test_gp_timer_trig.sv
`timescale 1ns/1ps
module test_gp_timer_trig;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        trgo;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gp_timer_trig i_gp_timer_trig (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .trgo(trgo)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input int d);
    wr_en = 1'b1; addr = a; wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_pulse(output int stamp);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trgo && n < 2000);
    stamp = cyc;
    if (!trgo) check("pulse timeout", 0, 1);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trgo) hi++;
    end
  endtask

  // Stop, program divider/limit, force update, then run in the given mode
  task automatic setup(input int div, input int lim, input int mode);
    wr(4'h0, mode << 4);
    wr(4'h1, div);
    wr(4'h2, lim);
    wr(4'h4, 1);
    wr(4'h0, (mode << 4) | 1);
  endtask

  task automatic t_reset;
    int v;
    check("R1 trgo", int'(trgo), 0);
    check("R1 rdata", int'(rdata), 0);
    rd(4'h0, v); check("R1 ctrl", v, 0);
    rd(4'h6, v); check("R1 count", v, 0);
    rd(4'h2, v); check("R1 limit", v, 0);
  endtask

  task automatic t_period;
    int s0, s1, s2;
    setup(2, 4, 2);
    wait_pulse(s0);
    @(negedge clk);
    check("R7 update pulse width", int'(trgo), 0);
    wait_pulse(s1);
    check("R2 R3 period div2 lim4", s1 - s0, 15);
    setup(0, 6, 2);
    wait_pulse(s1);
    wait_pulse(s2);
    check("R3 period div0 lim6", s2 - s1, 7);
  endtask

  task automatic t_preload;
    int s0, s1, s2, s3, s4;
    wr(4'h0, 16'h22);
    wr(4'h1, 0);
    wr(4'h2, 4);
    wr(4'h4, 1);
    wr(4'h0, 16'h23);
    wait_pulse(s0);
    wr(4'h2, 9);
    wait_pulse(s1);
    check("R4 staged limit not yet active", s1 - s0, 5);
    wait_pulse(s2);
    check("R4 staged limit active after update", s2 - s1, 10);
    wr(4'h0, 16'h21);
    wr(4'h2, 6);
    wait_pulse(s3);
    wait_pulse(s4);
    check("R4 direct limit without preload", s4 - s3, 7);
  endtask

  task automatic t_force_freeze;
    int v, a, b;
    setup(0, 1000, 0);
    idle(20);
    wr(4'h4, 1);
    check("R7 source 0 pulse on forced update", int'(trgo), 1);
    rd(4'h6, v);
    check("R6 count restarts at zero", v, 0);
    check("R7 source 0 pulse is one cycle", int'(trgo), 0);
    rd(4'h4, v);
    check("R6 force register reads zero", v, 0);
    idle(20);
    wr(4'h0, 0);
    rd(4'h6, a);
    idle(10);
    rd(4'h6, b);
    check("R5 count held when stopped", b, a);
    check("R5 count had advanced", int'(a > 10), 1);
  endtask

  task automatic t_enable_src;
    wr(4'h0, 16'h11);
    idle(3);
    check("R7 source 1 follows run high", int'(trgo), 1);
    wr(4'h0, 16'h10);
    idle(3);
    check("R7 source 1 follows run low", int'(trgo), 0);
  endtask

  task automatic t_match;
    int hi;
    wr(4'h8, 3);
    wr(4'h3, 1);
    setup(0, 9, 3);
    count_high(30, hi);
    check("R8 match pulses with channel enabled", hi, 3);
    wr(4'h3, 0);
    count_high(30, hi);
    check("R8 no pulses with channel disabled", hi, 0);
  endtask

  task automatic t_levels;
    int hi;
    wr(4'ha, 6);
    wr(4'hb, 0);
    wr(4'h9, 12);
    setup(0, 9, 6);
    count_high(30, hi);
    check("R9 channel 2 level duty", hi, 18);
    wr(4'h0, 16'h71);
    idle(2);
    count_high(30, hi);
    check("R9 channel 3 compare zero never high", hi, 0);
    wr(4'h0, 16'h51);
    idle(2);
    count_high(30, hi);
    check("R9 channel 1 compare above limit always high", hi, 30);
  endtask

  task automatic t_status;
    int v;
    wr(4'h0, 0);
    wr(4'h5, 1);
    rd(4'h5, v);
    check("R10 flag cleared and stopped", v, 0);
    wr(4'h4, 1);
    rd(4'h5, v);
    check("R10 flag set by forced update", v & 1, 1);
    wr(4'h1, 0);
    wr(4'h2, 500);
    wr(4'h4, 1);
    wr(4'h5, 1);
    wr(4'h0, 1);
    rd(4'h5, v);
    check("R10 running with flag clear", v, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period();
    t_preload();
    t_force_freeze();
    t_enable_src();
    t_match();
    t_levels();
    t_status();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule